// File: doc/BRIEF.md
# Bus-Matching Read Unpacker with Byte Swap

This block sits on the read side of a queue of 36-bit long words, each made of four 9-bit bytes, and feeds an output register that software sees as 36, 18 or 9 bits wide. In the narrow widths one long word is taken from the queue on the first read. That read puts the first piece on the output, and the remaining pieces are parked in a holding register. Later reads with the same setting emit those pieces without touching the queue. The four bytes can be reordered by one of four swap patterns. The swap is applied before the word is split into pieces.

The width and endianness controls pass through a register before they are used. The swap pattern is captured once per long word. The width code `11` turns a read into a read of an inbound mailbox value and a write into a load of an outbound mailbox register. A mailbox access leaves any half-finished long word in place, so the queue sequence picks up again on the next read.

Top module: `rd_unpacker`

## Requirements
- R1: While `rst_n` is low, `dout` and `mb2_q` are cleared, `fifo_pop` is low, and no long word is held.
- R2: `size_sel` and `big_end` are captured on every rising clock edge. A read uses the values captured on the previous edge, not the values present at its own edge.
- R3: A clock edge with `rd_en` low pops nothing and leaves `dout` unchanged.
- R4: Size code 00 (long word): every read raises `fifo_pop` and loads the whole long word, after swapping, into `dout`.
- R5: Size codes 01 (word, two pieces) and 10 (byte, four pieces): the read that starts a long word raises `fifo_pop` and outputs piece 0. Each further read with an unchanged setting outputs the next piece with `fifo_pop` low. The read after the last piece pops again.
- R6: A read whose captured size or endianness differs from that of the held long word pops a new long word and outputs its piece 0. The unread pieces of the old word are discarded.
- R7: With `big_end`=1 the pieces leave most significant first: bytes 35:27, 26:18, 17:9, 8:0, or words 35:18 then 17:0. With `big_end`=0 they leave least significant first. A piece sits on `dout[8:0]` (byte) or `dout[17:0]` (word), and the bits above it are zero.
- R8: Swap codes, with bytes named B3 (bits 35:27) down to B0, give these orders from high to low: 00 B3 B2 B1 B0; 01 B0 B1 B2 B3; 10 B1 B0 B3 B2; 11 B2 B3 B0 B1.
- R9: `swap_sel` is sampled only on a read that pops. Every piece of that long word uses the sampled pattern, whatever `swap_sel` does later.
- R10: When swapping and narrowing are combined, the pieces are cut from the swapped long word.
- R11: With captured size code 11, a read loads `mb1_data` into `dout` unchanged, with no swap, no narrowing and no pop.
- R12: With captured size code 11, `wr_en` loads `mb_wdata` into `mb2_q`. `wr_en` under any other size code has no effect.
- R13: A mailbox access does not change the held long word or the piece position. A later read with the earlier setting continues with the next piece and does not pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| size_sel | input | 2 | Width code: 00 long word, 01 word, 10 byte, 11 mailbox |
| big_end | input | 1 | 1 = most significant piece first |
| swap_sel | input | 2 | Byte reorder pattern for the next popped long word |
| rd_en | input | 1 | Read request for this edge |
| wr_en | input | 1 | Mailbox write request for this edge |
| fifo_data | input | 36 | Head long word of the queue |
| fifo_pop | output | 1 | Queue head is consumed on this edge |
| mb1_data | input | 36 | Inbound mailbox value |
| mb_wdata | input | 36 | Data for a mailbox write |
| mb2_q | output | 36 | Outbound mailbox register |
| dout | output | 36 | Output register |

## Verification
A change on `size_sel` or `big_end` takes effect one edge after it is driven, so the bench always spends one idle edge after changing them. The one exception is the R2 test, which changes them on the read's own edge on purpose. `fifo_pop` is combinational from the read request and the captured state. The bench samples it one time step after driving `rd_en`, before the edge. `dout` and `mb2_q` are registered, so the bench compares them at the falling edge that follows the read or write edge, against pieces it computes from its own model of the queue.

// File: rtl/unp_pkg.sv
package unp_pkg;
  localparam int unsigned BW = 9;
  localparam int unsigned NB = 4;
  localparam int unsigned LW = NB * BW;
  localparam int unsigned HW = 2 * BW;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_MAIL = 2'b11
  } size_e;

  // byte reorder, whole bytes only
  function automatic logic [LW-1:0] swap_lw(input logic [LW-1:0] w, input logic [1:0] mode);
    logic [BW-1:0] b0, b1, b2, b3;
    b0 = w[0*BW +: BW];
    b1 = w[1*BW +: BW];
    b2 = w[2*BW +: BW];
    b3 = w[3*BW +: BW];
    case (mode)
      2'b01:   swap_lw = {b0, b1, b2, b3};
      2'b10:   swap_lw = {b1, b0, b3, b2};
      2'b11:   swap_lw = {b2, b3, b0, b1};
      default: swap_lw = w;
    endcase
  endfunction

  // pieces still parked after the first one is emitted
  function automatic logic [1:0] rest_after_first(input size_e sz);
    case (sz)
      SZ_BYTE: rest_after_first = 2'd3;
      SZ_WORD: rest_after_first = 2'd1;
      default: rest_after_first = 2'd0;
    endcase
  endfunction

  // select piece k of a long word, placed on the low lanes
  function automatic logic [LW-1:0] pick_piece(input logic [LW-1:0] w, input size_e sz,
                                               input logic be, input logic [1:0] k);
    logic [1:0] bi;
    logic       hi;
    bi = be ? ~k : k;
    hi = be ? ~k[0] : k[0];
    pick_piece = '0;
    case (sz)
      SZ_BYTE: pick_piece[BW-1:0] = w[int'(bi)*BW +: BW];
      SZ_WORD: pick_piece[HW-1:0] = w[int'(hi)*HW +: HW];
      default: pick_piece = w;
    endcase
  endfunction
endpackage

// File: rtl/unp_cfg_reg.sv
module unp_cfg_reg
  import unp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] size_sel,
  input  logic       big_end,
  output size_e      size_q,
  output logic       be_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SZ_LONG;
      be_q   <= 1'b0;
    end else begin
      size_q <= size_e'(size_sel);
      be_q   <= big_end;
    end
  end

  p_cfg_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (size_q == size_e'($past(size_sel)) && be_q == $past(big_end)));
endmodule

// File: rtl/unp_seq.sv
module unp_seq
  import unp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_go,
  input  size_e      size_q,
  input  logic       be_q,
  output logic       fetch,
  output logic       cont,
  output logic [1:0] idx_use
);
  logic [1:0] rem;
  logic [1:0] idx;
  size_e      held_size;
  logic       held_be;
  logic       setting_moved;

  assign setting_moved = (size_q != held_size) || (be_q != held_be);
  assign fetch   = rd_go && ((rem == 2'd0) || setting_moved);
  assign cont    = rd_go && !fetch;
  assign idx_use = fetch ? 2'd0 : idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem       <= 2'd0;
      idx       <= 2'd0;
      held_size <= SZ_LONG;
      held_be   <= 1'b0;
    end else if (fetch) begin
      rem       <= rest_after_first(size_q);
      idx       <= 2'd1;
      held_size <= size_q;
      held_be   <= be_q;
    end else if (cont) begin
      rem <= rem - 2'd1;
      idx <= idx + 2'd1;
    end
  end

  p_long_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && size_q == SZ_LONG) |=> (rem == 2'd0));
  p_cont_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cont |=> (rem == $past(rem) - 2'd1));
  p_keep_state_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> ($stable(rem) && $stable(idx)));
endmodule

// File: rtl/unp_dpath.sv
module unp_dpath
  import unp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch,
  input  logic          cont,
  input  logic          mb_rd,
  input  logic          mb_wr,
  input  logic [1:0]    idx_use,
  input  size_e         size_q,
  input  logic          be_q,
  input  logic [1:0]    swap_sel,
  input  logic [LW-1:0] fifo_data,
  input  logic [LW-1:0] mb1_data,
  input  logic [LW-1:0] mb_wdata,
  output logic [LW-1:0] dout,
  output logic [LW-1:0] mb2_q
);
  logic [LW-1:0] hold;
  logic [LW-1:0] swapped;
  logic [LW-1:0] src;

  assign swapped = swap_lw(fifo_data, swap_sel);
  assign src     = fetch ? swapped : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      dout <= '0;
    end else if (fetch || cont) begin
      if (fetch) hold <= swapped;
      dout <= pick_piece(src, size_q, be_q, idx_use);
    end else if (mb_rd) begin
      dout <= mb1_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mb2_q <= '0;
    else if (mb_wr) mb2_q <= mb_wdata;
  end

  p_hold_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch |=> $stable(hold));
  p_mb_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rd |=> (dout == $past(mb1_data)));
  p_mb_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mb_wr |=> (mb2_q == $past(mb_wdata)));
  p_mb_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !mb_wr |=> $stable(mb2_q));
endmodule

// File: rtl/rd_unpacker.sv
module rd_unpacker
  import unp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    size_sel,
  input  logic          big_end,
  input  logic [1:0]    swap_sel,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [LW-1:0] fifo_data,
  output logic          fifo_pop,
  input  logic [LW-1:0] mb1_data,
  input  logic [LW-1:0] mb_wdata,
  output logic [LW-1:0] mb2_q,
  output logic [LW-1:0] dout
);
  size_e      size_q;
  logic       be_q;
  logic       is_mail;
  logic       rd_go;
  logic       mb_rd;
  logic       mb_wr;
  logic       fetch;
  logic       cont;
  logic [1:0] idx_use;

  assign is_mail  = (size_q == SZ_MAIL);
  assign rd_go    = rd_en && !is_mail;
  assign mb_rd    = rd_en && is_mail;
  assign mb_wr    = wr_en && is_mail;
  assign fifo_pop = fetch;

  unp_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .big_end(big_end),
    .size_q(size_q), .be_q(be_q)
  );

  unp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .size_q(size_q), .be_q(be_q),
    .fetch(fetch), .cont(cont), .idx_use(idx_use)
  );

  unp_dpath u_dp (
    .clk(clk), .rst_n(rst_n), .fetch(fetch), .cont(cont), .mb_rd(mb_rd),
    .mb_wr(mb_wr), .idx_use(idx_use), .size_q(size_q), .be_q(be_q),
    .swap_sel(swap_sel), .fifo_data(fifo_data), .mb1_data(mb1_data),
    .mb_wdata(mb_wdata), .dout(dout), .mb2_q(mb2_q)
  );

  p_pop_not_mail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_mail) |-> !fifo_pop);
endmodule

// File: tb/sim_rd_unpacker.sv
`timescale 1ns/1ps
module sim_rd_unpacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size_sel = 2'b00;
  logic        big_end = 1'b0;
  logic [1:0]  swap_sel = 2'b00;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [35:0] fifo_data;
  logic        fifo_pop;
  logic [35:0] mb1_data = '0;
  logic [35:0] mb_wdata = '0;
  logic [35:0] mb2_q;
  logic [35:0] dout;

  int n_chk = 0;
  int n_bad = 0;
  int head = 0;
  int fidx = 0;
  bit done = 0;
  logic [35:0] fmem [32];

  always #4 clk = ~clk;

  assign fifo_data = fmem[head];
  always @(posedge clk) if (rst_n && fifo_pop) head <= head + 1;

  rd_unpacker u0 (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .big_end(big_end),
    .swap_sel(swap_sel), .rd_en(rd_en), .wr_en(wr_en), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .mb1_data(mb1_data), .mb_wdata(mb_wdata),
    .mb2_q(mb2_q), .dout(dout)
  );

  // expected piece: byte at position p of the swapped word comes from p ^ key
  function automatic logic [35:0] want(int wi, int mode, int sz, bit be, int k);
    logic [8:0] o [4];
    int key;
    int sel;
    key = (mode == 1) ? 3 : (mode == 2) ? 2 : (mode == 3) ? 1 : 0;
    for (int p = 0; p < 4; p++) o[p] = fmem[wi][9*(p ^ key) +: 9];
    want = '0;
    if (sz == 2) begin
      sel = be ? 3 - k : k;
      want[8:0] = o[sel];
    end else if (sz == 1) begin
      sel = be ? 1 - k : k;
      want[17:0] = {o[2*sel+1], o[2*sel]};
    end else begin
      want = {o[3], o[2], o[1], o[0]};
    end
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(int sz, bit be);
    size_sel = 2'(sz);
    big_end = be;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_rd(int sw, output logic popped);
    rd_en = 1'b1;
    swap_sel = 2'(sw);
    #1 popped = fifo_pop;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 dout", dout, '0);
    chk("R1 mb2", mb2_q, '0);
    chk("R1 pop", 36'(fifo_pop), 36'd0);
  endtask

  task automatic t_long();
    logic p;
    cfg(0, 1);
    for (int m = 0; m < 4; m++) begin
      do_rd(m, p);
      chk("R4 pop", 36'(p), 36'd1);
      chk("R8 swap long", dout, want(fidx, m, 0, 1, 0));
      fidx++;
    end
  endtask

  task automatic t_byte_be();
    logic p;
    cfg(2, 1);
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k < 4; k++) begin
        do_rd(0, p);
        chk("R5 pop", 36'(p), 36'(k == 0));
        chk("R7 byte be", dout, want(fidx, 0, 2, 1, k));
      end
      fidx++;
    end
  endtask

  task automatic t_word_le();
    logic p;
    cfg(1, 0);
    for (int k = 0; k < 2; k++) begin
      do_rd(0, p);
      chk("R5 word pop", 36'(p), 36'(k == 0));
      chk("R7 word le", dout, want(fidx, 0, 1, 0, k));
    end
    fidx++;
  endtask

  task automatic t_swap_freeze();
    logic p;
    cfg(2, 0);
    do_rd(1, p);
    chk("R9 pop", 36'(p), 36'd1);
    chk("R10 first", dout, want(fidx, 1, 2, 0, 0));
    for (int k = 1; k < 4; k++) begin
      do_rd(2, p);
      chk("R9 frozen", dout, want(fidx, 1, 2, 0, k));
    end
    fidx++;
    cfg(1, 1);
    do_rd(3, p);
    chk("R10 word swap", dout, want(fidx, 3, 1, 1, 0));
    do_rd(0, p);
    chk("R10 word swap 2", dout, want(fidx, 3, 1, 1, 1));
    fidx++;
  endtask

  task automatic t_change();
    logic p;
    cfg(2, 1);
    do_rd(0, p);
    chk("R6 start", dout, want(fidx, 0, 2, 1, 0));
    fidx++;
    cfg(1, 1);
    do_rd(0, p);
    chk("R6 refetch pop", 36'(p), 36'd1);
    chk("R6 new word", dout, want(fidx, 0, 1, 1, 0));
    cfg(1, 0);
    do_rd(0, p);
    chk("R6 endian change pop", 36'(p), 36'd1);
    fidx++;
    chk("R6 endian new", dout, want(fidx, 0, 1, 0, 0));
    do_rd(0, p);
    fidx++;
  endtask

  task automatic t_mail();
    logic p;
    cfg(2, 1);
    do_rd(0, p);
    chk("R13 first", dout, want(fidx, 0, 2, 1, 0));
    cfg(3, 1);
    mb1_data = 36'hA_5C3C_0F96;
    do_rd(2, p);
    chk("R11 no pop", 36'(p), 36'd0);
    chk("R11 mail read", dout, 36'hA_5C3C_0F96);
    mb_wdata = 36'h3_1234_ABCD;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R12 mail write", mb2_q, 36'h3_1234_ABCD);
    cfg(2, 1);
    for (int k = 1; k < 4; k++) begin
      do_rd(0, p);
      chk("R13 resume pop", 36'(p), 36'd0);
      chk("R13 resume", dout, want(fidx, 0, 2, 1, k));
    end
    fidx++;
  endtask

  task automatic t_ignored();
    logic [35:0] keep;
    cfg(1, 1);
    keep = dout;
    mb_wdata = 36'hF_FFFF_0000;
    wr_en = 1'b1;
    #1 chk("R3 idle pop", 36'(fifo_pop), 36'd0);
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R12 write ignored", mb2_q, 36'h3_1234_ABCD);
    chk("R3 dout held", dout, keep);
  endtask

  task automatic t_sample();
    logic p;
    // size_q is word (1, be=1); drive long on the read edge itself
    size_sel = 2'b00;
    rd_en = 1'b1;
    swap_sel = 2'b00;
    #1 p = fifo_pop;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R2 pop", 36'(p), 36'd1);
    chk("R2 old size used", dout, want(fidx, 0, 1, 1, 0));
    fidx++;
    do_rd(0, p);
    chk("R6 drop leftover", 36'(p), 36'd1);
    chk("R4 long after", dout, want(fidx, 0, 0, 1, 0));
    fidx++;
  endtask

  initial begin
    for (int i = 0; i < 32; i++)
      for (int p = 0; p < 4; p++)
        fmem[i][9*p +: 9] = 9'(i * 37 + p * 83 + 5);
    @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_long();
    t_byte_be();
    t_word_le();
    t_swap_freeze();
    t_change();
    t_mail();
    t_ignored();
    t_sample();
    chk("R4 queue position", 36'(head), 36'(fidx));
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule